// File: doc/BRIEF.md
# Program Address Register File

This block keeps the four 12-bit address registers of a small 8-bit microcontroller core. They are the program counter, a one-level return register (the stack register), a primary data pointer and an auxiliary data pointer. A control unit drives a 4-bit command code once per cycle, together with an 8-bit data byte. The block updates its registers on the rising clock edge. It always presents a memory address taken from either the program counter or the primary data pointer.

One 12-bit adder does all the address arithmetic. It can step the program counter or the primary data pointer by one. It can also add a sign-extended byte, either to the program counter as a relative branch or to the primary data pointer as a table offset. The two data pointers can trade places, but only the primary one can reach the address bus. The stack register takes the program counter on calls and interrupts, and gives it back on return. Its contents can be read and written as a low byte and a high nibble, so software can spill it into scratch registers.

Top module: `pgm_addr_file`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the stack register and both data pointers to 0x000, so `mem_addr` reads 0x000 after reset.
- R2: Command 1 (step) places the program counter on `mem_addr` and adds one to it at the clock edge; 0xFFF wraps to 0x000.
- R3: Command 2 (data access) places the primary data pointer on `mem_addr` and then adds one to it; 0xFFF wraps to 0x000. Every other command places the program counter on `mem_addr`.
- R4: Command 3 (relative branch) adds the data byte, sign-extended from bit 7, to the program counter modulo 4096.
- R5: Command 4 (pointer offset) adds the data byte, sign-extended from bit 7, to the primary data pointer modulo 4096.
- R6: Command 8 (exchange) swaps the two data pointers; the auxiliary pointer is never placed on `mem_addr` directly.
- R7: Command 5 (call) copies the program counter into the stack register and leaves the program counter unchanged.
- R8: Command 6 (interrupt entry) copies the program counter into the stack register and loads the program counter with 0x020.
- R9: Command 7 (return) loads the program counter from the stack register.
- R10: Command 9 writes the data byte into stack bits 7:0, and command 10 writes data bits 3:0 into stack bits 11:8. `stk_lo` always shows stack bits 7:0, and `stk_hi` shows stack bits 11:8 in its bits 3:0 with zeros in bits 7:4.
- R11: Command 0 and the unused codes 11 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 4 | Command code for this cycle |
| data_in | input | 8 | Byte for branch, pointer offset and stack writes |
| mem_addr | output | 12 | Memory address: program counter or primary data pointer |
| stk_lo | output | 8 | Stack register bits 7:0 |
| stk_hi | output | 8 | Stack register bits 11:8, zero-extended |

## Verification
The bench walks both the program counter and the data pointer across the 0xFFF to 0x000 boundary. A design with a carry-out bug or a zero-extended displacement would land on the wrong address there. Negative displacements are applied to both registers: an unsigned add would move the address forward by about 256 instead of backward. The exchange is checked after the pointers hold different values. A design that let the auxiliary pointer onto the bus, or that copied one way only, would show a stale address on the next data access. The bench also checks a return right after an interrupt entry, then a nibble and byte rewrite of the stack register. It confirms that unused codes leave every register untouched.

// File: rtl/pafile_pkg.sv
package pafile_pkg;
   typedef enum logic [3:0] {
      PA_NOP     = 4'd0,
      PA_STEP    = 4'd1,
      PA_DACC    = 4'd2,
      PA_BRANCH  = 4'd3,
      PA_DOFS    = 4'd4,
      PA_CALL    = 4'd5,
      PA_IRQ     = 4'd6,
      PA_RET     = 4'd7,
      PA_XCHG    = 4'd8,
      PA_STK_LO  = 4'd9,
      PA_STK_HI  = 4'd10
   } pa_cmd_e;
endpackage

// File: rtl/pa_adder.sv
module pa_adder #(
   parameter int AW          = 12,
   parameter int DW          = 8,
   parameter bit SIGNED_BYTE = 1'b1
) (
   input  logic [AW-1:0] base,
   input  logic [DW-1:0] byte_in,
   input  logic          use_byte,
   output logic [AW-1:0] sum
);
   localparam int EXT_W = AW - DW;

   logic [AW-1:0] ext;

   generate
      if (SIGNED_BYTE) begin : g_sext
         assign ext = {{EXT_W{byte_in[DW-1]}}, byte_in};
      end else begin : g_zext
         assign ext = {{EXT_W{1'b0}}, byte_in};
      end
   endgenerate

   logic [AW-1:0] operand;
   assign operand = use_byte ? ext : AW'(1);
   assign sum     = base + operand;
endmodule

// File: rtl/pa_addr_sel.sv
module pa_addr_sel #(
   parameter int AW = 12
) (
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] dc,
   input  logic          use_dc,
   output logic [AW-1:0] addr
);
   assign addr = use_dc ? dc : pc;
endmodule

// File: rtl/pgm_addr_file.sv
module pgm_addr_file
   import pafile_pkg::*;
#(
   parameter int              ADDR_W      = 12,
   parameter int              DATA_W      = 8,
   parameter logic [11:0]     IRQ_VEC     = 12'h020,
   parameter bit              SIGNED_BYTE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [3:0]        cmd,
   input  logic [DATA_W-1:0] data_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] stk_lo,
   output logic [DATA_W-1:0] stk_hi
);
   localparam int HI_W  = ADDR_W - DATA_W;
   localparam int PAD_W = DATA_W - HI_W;

   generate
      if (ADDR_W <= DATA_W || HI_W > DATA_W) begin : g_bad_width
         $error("pgm_addr_file: ADDR_W must exceed DATA_W and be at most twice it");
      end
      if (ADDR_W < 12) begin : g_bad_vec
         $error("pgm_addr_file: ADDR_W too small for the interrupt vector parameter");
      end
   endgenerate

   pa_cmd_e c;
   assign c = pa_cmd_e'(cmd);

   logic [ADDR_W-1:0] pc_q, stk_q, dc_q, dc1_q;

   // shared adder operand selection
   logic              pc_side, use_byte;
   logic [ADDR_W-1:0] add_base, add_sum;

   assign pc_side  = (c == PA_STEP) || (c == PA_BRANCH);
   assign use_byte = (c == PA_BRANCH) || (c == PA_DOFS);
   assign add_base = pc_side ? pc_q : dc_q;

   pa_adder #(.AW(ADDR_W), .DW(DATA_W), .SIGNED_BYTE(SIGNED_BYTE)) u_adder (
      .base    (add_base),
      .byte_in (data_in),
      .use_byte(use_byte),
      .sum     (add_sum)
   );

   pa_addr_sel #(.AW(ADDR_W)) u_sel (
      .pc    (pc_q),
      .dc    (dc_q),
      .use_dc(c == PA_DACC),
      .addr  (mem_addr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         stk_q <= '0;
         dc_q  <= '0;
         dc1_q <= '0;
      end else begin
         case (c)
            PA_STEP, PA_BRANCH: pc_q <= add_sum;
            PA_DACC, PA_DOFS:   dc_q <= add_sum;
            PA_CALL:            stk_q <= pc_q;
            PA_IRQ: begin
               stk_q <= pc_q;
               pc_q  <= ADDR_W'(IRQ_VEC);
            end
            PA_RET:             pc_q <= stk_q;
            PA_XCHG: begin
               dc_q  <= dc1_q;
               dc1_q <= dc_q;
            end
            PA_STK_LO:          stk_q[DATA_W-1:0] <= data_in;
            PA_STK_HI:          stk_q[ADDR_W-1:DATA_W] <= data_in[HI_W-1:0];
            default: ;
         endcase
      end
   end

   assign stk_lo = stk_q[DATA_W-1:0];
   generate
      if (PAD_W > 0) begin : g_pad_hi
         assign stk_hi = {{PAD_W{1'b0}}, stk_q[ADDR_W-1:DATA_W]};
      end else begin : g_full_hi
         assign stk_hi = stk_q[ADDR_W-1:DATA_W];
      end
   endgenerate

   // assertions
   p_step_r2: assert property (@(posedge clk) disable iff (rst)
      (c == PA_STEP) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

   p_dacc_bus_r3: assert property (@(posedge clk) disable iff (rst)
      (c == PA_DACC) |-> (mem_addr == dc_q));

   p_xchg_r6: assert property (@(posedge clk) disable iff (rst)
      (c == PA_XCHG) |=> (dc_q == $past(dc1_q)) && (dc1_q == $past(dc_q)));

   p_call_r7: assert property (@(posedge clk) disable iff (rst)
      (c == PA_CALL) |=> (stk_q == $past(pc_q)) && $stable(pc_q));

   p_irq_r8: assert property (@(posedge clk) disable iff (rst)
      (c == PA_IRQ) |=> (pc_q == ADDR_W'(IRQ_VEC)) && (stk_q == $past(pc_q)));

   p_ret_r9: assert property (@(posedge clk) disable iff (rst)
      (c == PA_RET) |=> (pc_q == $past(stk_q)));

   p_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (c == PA_NOP) |=> $stable(pc_q) && $stable(dc_q) && $stable(dc1_q) && $stable(stk_q));
endmodule

// File: tb/pgm_addr_file_bench.sv
`timescale 1ns/1ps
module pgm_addr_file_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] cmd = 4'd0;
   logic [7:0] data = 8'd0;
   logic [11:0] mem_addr;
   logic [7:0]  stk_lo, stk_hi;

   always #4 clk = ~clk;

   pgm_addr_file u_pgm_addr_file (
      .clk(clk), .rst(rst), .cmd(cmd), .data_in(data),
      .mem_addr(mem_addr), .stk_lo(stk_lo), .stk_hi(stk_hi)
   );

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   logic [11:0] m_pc = '0, m_dc = '0, m_dc1 = '0, m_stk = '0;

   localparam int NV = 20;
   localparam logic [11:0] VEC [NV] = '{
      {4'd1, 8'h00}, {4'd1, 8'h00}, {4'd3, 8'h05}, {4'd3, 8'hFC},
      {4'd4, 8'h10}, {4'd2, 8'h00}, {4'd4, 8'hF0}, {4'd8, 8'h00},
      {4'd2, 8'h00}, {4'd8, 8'h00}, {4'd5, 8'h00}, {4'd3, 8'h40},
      {4'd6, 8'h00}, {4'd1, 8'h00}, {4'd7, 8'h00}, {4'd9, 8'hAB},
      {4'd10, 8'hF5}, {4'd7, 8'h00}, {4'd15, 8'h33}, {4'd0, 8'h77}
   };

   function automatic string tag(input logic [3:0] c);
      case (c)
         4'd1: return "R2 step";
         4'd2: return "R3 data access";
         4'd3: return "R4 branch";
         4'd4: return "R5 pointer offset";
         4'd5: return "R7 call";
         4'd6: return "R8 interrupt";
         4'd7: return "R9 return";
         4'd8: return "R6 exchange";
         4'd9, 4'd10: return "R10 stack write";
         default: return "R11 no-op";
      endcase
   endfunction

   task automatic chk(input string lbl, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", lbl, act, exp);
      end
   endtask

   function automatic logic [11:0] sx(input logic [7:0] d);
      return {{4{d[7]}}, d};
   endfunction

   task automatic model(input logic [3:0] c, input logic [7:0] d);
      logic [11:0] t;
      case (c)
         4'd1: m_pc = m_pc + 12'd1;
         4'd2: m_dc = m_dc + 12'd1;
         4'd3: m_pc = m_pc + sx(d);
         4'd4: m_dc = m_dc + sx(d);
         4'd5: m_stk = m_pc;
         4'd6: begin m_stk = m_pc; m_pc = 12'h020; end
         4'd7: m_pc = m_stk;
         4'd8: begin t = m_dc; m_dc = m_dc1; m_dc1 = t; end
         4'd9: m_stk[7:0] = d;
         4'd10: m_stk[11:8] = d[3:0];
         default: ;
      endcase
   endtask

   task automatic step(input logic [3:0] c, input logic [7:0] d);
      @(negedge clk);
      cmd = c; data = d;
      #1;
      chk(tag(c), mem_addr, (c == 4'd2) ? m_dc : m_pc);
      chk("R10 stk_lo", {4'h0, stk_lo}, {4'h0, m_stk[7:0]});
      chk("R10 stk_hi", {4'h0, stk_hi}, {8'h00, m_stk[11:8]});
      @(posedge clk);
      model(c, d);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; cmd = 4'd0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_pc = '0; m_dc = '0; m_dc1 = '0; m_stk = '0;
   endtask

   initial begin
      do_reset();
      // R1 reset state
      #1;
      chk("R1 reset pc on bus", mem_addr, 12'h000);
      chk("R1 reset stk_lo", {4'h0, stk_lo}, 12'h000);
      chk("R1 reset stk_hi", {4'h0, stk_hi}, 12'h000);

      for (int i = 0; i < NV; i++) step(VEC[i][11:8], VEC[i][7:0]);

      // reset mid-run clears everything, including the auxiliary pointer (R1)
      do_reset();
      step(4'd2, 8'h00);            // primary pointer back at 0
      chk("R1 primary pointer after reset", m_dc, 12'h001);
      step(4'd8, 8'h00);
      step(4'd2, 8'h00);            // auxiliary pointer was 0

      // program counter wrap (R2, R4)
      do_reset();
      step(4'd3, 8'hFF);            // 0 - 1
      #1 chk("R4 negative branch to 0xFFF", mem_addr, 12'hFFF);
      step(4'd1, 8'h00);
      #1 chk("R2 step wraps to 0x000", mem_addr, 12'h000);

      // data pointer wrap (R3, R5)
      step(4'd4, 8'hFF);
      step(4'd2, 8'h00);            // shows 0xFFF, then wraps
      step(4'd2, 8'h00);            // shows 0x000
      // auxiliary pointer never on bus (R6)
      step(4'd4, 8'h30);
      step(4'd8, 8'h00);            // dc=0, aux=0x031
      step(4'd2, 8'h00);
      step(4'd8, 8'h00);
      step(4'd2, 8'h00);            // 0x031
      // interrupt then return (R8, R9)
      step(4'd3, 8'h7F);
      step(4'd6, 8'h00);
      step(4'd7, 8'h00);
      // unused codes (R11)
      for (int k = 11; k < 16; k++) step(k[3:0], 8'hA5);
      step(4'd0, 8'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R1-to-R11 run: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule